// File: doc/BRIEF.md
# Stand-Alone Fault Autoretry and Flag Stretcher

This block runs the output channels of a dual line driver when no host controller is present. In that case a host cannot clear faults or turn channels back on. The block watches the fault conditions that switch a channel off: a short to supply or ground on one channel, and overvoltage on the supply. When one of these occurs, the block holds the affected output disabled for a fixed retry interval and then enables it again. If the fault is still there, the channel trips again and the cycle repeats.

Each trip also drives the active-low fault flag low for a fixed pulse width. A trip that arrives while a pulse is already running restarts the pulse rather than adding a second one.

The block is active only while both address strap inputs are low. With any other strap setting it stays idle and passes every channel through as enabled. Both intervals are parameters counted in clock cycles. Each channel has its own retry timer. An overvoltage event disables all channels at once and releases them together.

Top module: `sa_retry_ctrl`

## Requirements
- R1: After reset every bit of `ch_en` is 1 and `flag_n` is 1.
- R2: When `strap` is not 2'b00 (host mode), fault inputs have no effect: `ch_en` stays all ones and `flag_n` stays 1.
- R3: In stand-alone mode (`strap` == 2'b00), a fault on channel i while it is enabled drives `ch_en[i]` low from the clock edge that samples the fault. It stays low for exactly RETRY_CYC cycles and then returns to 1. Other channels are not affected.
- R4: If a channel fault persists, the channel is re-enabled for one cycle, then trips again and starts a new retry interval and a new flag pulse.
- R5: An overvoltage fault while all channels are enabled drives every bit of `ch_en` low on the same edge. All bits return to 1 together after RETRY_CYC cycles.
- R6: Every trip drives `flag_n` low from the same edge that disables the channel, for FLAG_CYC cycles.
- R7: A trip while `flag_n` is already low restarts the pulse, so `flag_n` stays low until FLAG_CYC cycles after the latest trip.
- R8: A fault on a channel whose own retry timer is already running does not lengthen its off time and does not retrigger the flag.
- R9: Leaving stand-alone mode aborts all pending retries and pulses. On the next edge `ch_en` is all ones and `flag_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 2 | Address strap levels; 2'b00 selects stand-alone mode |
| ch_fault | input | NUM_CH | Per-channel shutdown fault (short to supply or ground) |
| ovv_fault | input | 1 | Supply overvoltage fault, shared by all channels |
| ch_en | output | NUM_CH | Per-channel output enable, 1 = driving, 0 = high impedance |
| flag_n | output | 1 | Active-low stretched fault flag |

## Verification
The bench measures the exact off window of a channel, both at its last low cycle and at its first high cycle. A design with an off-by-one counter would therefore fail at one end of the window. A fault pulse injected partway through a retry interval exposes a design that reloads its timer or restarts the flag while a channel is already off. Two staggered trips check that the flag ends a full pulse after the second trip; overlapping or non-restarting pulses would release it too early. A persistent fault checks the single re-enable cycle and the second flag pulse. A strap change during a retry checks that the design drops its state at once instead of finishing the interval.

// File: rtl/sa_retry_pkg.sv
package sa_retry_pkg;

    localparam int STRAP_W = 2;

    // Stand-alone operation is chosen when every strap input is low.
    function automatic logic standalone_sel(input logic [STRAP_W-1:0] strap_lvl);
        return (strap_lvl == '0);
    endfunction

endpackage

// File: rtl/sa_retry_timer.sv
module sa_retry_timer #(
    parameter int HOLD_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic fault,
    output logic run,
    output logic trip
);
    localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          off;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    // A trip is recognised only while the output is running.
    assign trip = active & ~st_q.off & fault;
    assign run  = ~st_q.off;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.off = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.off) begin
            if (fault) begin
                st_d.off = 1'b1;
                st_d.cnt = RELOAD;
            end
        end else if (st_q.cnt == '0) begin
            st_d.off = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sa_flag_stretch.sv
module sa_flag_stretch #(
    parameter int PULSE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic trig,
    output logic flag_n
);
    localparam int CW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYC - 1);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } pls_t;

    pls_t st_d, st_q;

    assign flag_n = ~st_q.on;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (trig) begin
            // a fresh trip restarts the pulse from its full width
            st_d.on  = 1'b1;
            st_d.cnt = RELOAD;
        end else if (st_q.on) begin
            if (st_q.cnt == '0) begin
                st_d.on = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sa_retry_ctrl.sv
module sa_retry_ctrl
    import sa_retry_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int RETRY_CYC = 500,
    parameter int FLAG_CYC  = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic [NUM_CH-1:0]  ch_fault,
    input  logic               ovv_fault,
    output logic [NUM_CH-1:0]  ch_en,
    output logic               flag_n
);
    localparam int NSRC = NUM_CH + 1;

    logic              sa_mode;
    logic [NUM_CH-1:0] ch_run;
    logic [NSRC-1:0]   trips;
    logic              ovv_run;

    assign sa_mode = standalone_sel(strap);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sa_retry_timer #(.HOLD_CYC(RETRY_CYC)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (sa_mode),
            .fault  (ch_fault[g]),
            .run    (ch_run[g]),
            .trip   (trips[g])
        );
    end

    // One shared timer for supply overvoltage gates every channel.
    sa_retry_timer #(.HOLD_CYC(RETRY_CYC)) u_ovv_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (sa_mode),
        .fault  (ovv_fault),
        .run    (ovv_run),
        .trip   (trips[NUM_CH])
    );

    sa_flag_stretch #(.PULSE_CYC(FLAG_CYC)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (sa_mode),
        .trig   (|trips),
        .flag_n (flag_n)
    );

    assign ch_en = ch_run & {NUM_CH{ovv_run}};
endmodule

// File: rtl/sa_retry_ctrl_chk.sv
module sa_retry_ctrl_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        strap,
    input logic [NUM_CH-1:0] ch_fault,
    input logic              ovv_fault,
    input logic [NUM_CH-1:0] ch_en,
    input logic              flag_n
);
    logic sa;
    assign sa = (strap == 2'b00);

    assert_idle_host_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sa |=> ((&ch_en) && flag_n));

    assert_ovv_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sa && ovv_fault && (&ch_en)) |=> (ch_en == '0));

    assert_flag_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_n) |-> $past(sa));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_trip_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sa && ch_fault[g] && ch_en[g]) |=> !ch_en[g]);

        assert_trip_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (sa && ch_fault[g] && ch_en[g]) |=> !flag_n);

        assert_off_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_en[g]) |-> ($past(sa) && ($past(ch_fault[g]) || $past(ovv_fault))));
    end
endmodule

bind sa_retry_ctrl sa_retry_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap),
    .ch_fault  (ch_fault),
    .ovv_fault (ovv_fault),
    .ch_en     (ch_en),
    .flag_n    (flag_n)
);

// File: tb/sa_retry_ctrl_tb_top.sv
module sa_retry_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int R = 20;
    localparam int F = 8;
    localparam int WDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap = 2'b00;
    logic [1:0] ch_fault = 2'b00;
    logic       ovv_fault = 1'b0;
    logic [1:0] ch_en;
    logic       flag_n;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [1:0] en;
        logic       fl;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sa_retry_ctrl #(.NUM_CH(2), .RETRY_CYC(R), .FLAG_CYC(F)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap),
        .ch_fault  (ch_fault),
        .ovv_fault (ovv_fault),
        .ch_en     (ch_en),
        .flag_n    (flag_n)
    );

    task automatic cmp(input logic [1:0] en, input logic fl, input string tag);
        checks++;
        if (ch_en !== en || flag_n !== fl) begin
            errors++;
            $display("FAIL %s cyc=%0d actual en=%b flag_n=%b expected en=%b flag_n=%b",
                     tag, cyc, ch_en, flag_n, en, fl);
        end
    endtask

    // Monitor: pops every expected item due at this sample point.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.en, e.fl, e.tag);
        end
    end

    task automatic expect_at(input int base, input int off, input logic [1:0] en,
                             input logic fl, input string tag);
        exp_t e;
        e.at = base + off; e.en = en; e.fl = fl; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        step(R + F + 4);
    endtask

    initial begin
        int b;
        step(3);
        cmp(2'b11, 1'b1, "R1 in reset");
        rst_n = 1'b1;
        step(2);
        cmp(2'b11, 1'b1, "R1 after reset");

        // R2: host mode straps ignore faults
        for (int s = 1; s < 4; s++) begin
            strap = 2'(s);
            step(1);
            b = cyc;
            expect_at(b, 1, 2'b11, 1'b1, "R2 host fault ignored");
            expect_at(b, 3, 2'b11, 1'b1, "R2 host fault ignored");
            expect_at(b, 6, 2'b11, 1'b1, "R2 host ovv ignored");
            ch_fault = 2'b11; ovv_fault = 1'b1;
            step(3);
            ch_fault = 2'b00; ovv_fault = 1'b0;
            step(4);
        end
        strap = 2'b00;
        drain();

        // R3, R6, R8: single-cycle fault on ch0, then a second fault during the off time
        b = cyc;
        expect_at(b, 1, 2'b10, 1'b0, "R3 R6 ch0 trip");
        expect_at(b, F, 2'b10, 1'b0, "R6 flag last low");
        expect_at(b, F + 1, 2'b10, 1'b1, "R6 R8 flag ends, no retrigger");
        expect_at(b, R, 2'b10, 1'b1, "R3 R8 ch0 last off cycle");
        expect_at(b, R + 1, 2'b11, 1'b1, "R3 R8 ch0 re-enabled");
        ch_fault = 2'b01;
        step(1);
        ch_fault = 2'b00;
        step(4);
        ch_fault = 2'b01;
        step(1);
        ch_fault = 2'b00;
        drain();

        // R4: persistent fault on ch1
        b = cyc;
        expect_at(b, 1, 2'b01, 1'b0, "R4 ch1 first trip");
        expect_at(b, R, 2'b01, 1'b1, "R4 ch1 still off");
        expect_at(b, R + 1, 2'b11, 1'b1, "R4 ch1 one-cycle re-enable");
        expect_at(b, R + 2, 2'b01, 1'b0, "R4 ch1 retrip with new pulse");
        expect_at(b, 2 * R + 1, 2'b01, 1'b1, "R4 ch1 second off window");
        ch_fault = 2'b10;
        step(R + 10);
        ch_fault = 2'b00;
        drain();

        // R7: staggered trips restart the flag pulse
        b = cyc;
        expect_at(b, 1, 2'b10, 1'b0, "R7 first trip");
        expect_at(b, 5, 2'b00, 1'b0, "R7 second trip");
        expect_at(b, F + 1, 2'b00, 1'b0, "R7 pulse extended");
        expect_at(b, F + 4, 2'b00, 1'b0, "R7 last low of restarted pulse");
        expect_at(b, F + 5, 2'b00, 1'b1, "R7 restarted pulse ends");
        expect_at(b, R + 1, 2'b01, 1'b1, "R3 ch0 back, ch1 independent");
        expect_at(b, R + 5, 2'b11, 1'b1, "R3 ch1 back");
        ch_fault = 2'b01;
        step(1);
        ch_fault = 2'b00;
        step(3);
        ch_fault = 2'b10;
        step(1);
        ch_fault = 2'b00;
        drain();

        // R5: overvoltage takes both channels off together
        b = cyc;
        expect_at(b, 1, 2'b00, 1'b0, "R5 ovv both off");
        expect_at(b, R, 2'b00, 1'b1, "R5 both still off");
        expect_at(b, R + 1, 2'b11, 1'b1, "R5 both back together");
        ovv_fault = 1'b1;
        step(1);
        ovv_fault = 1'b0;
        drain();

        // R9: leaving stand-alone mode mid-retry
        b = cyc;
        expect_at(b, 3, 2'b10, 1'b0, "R9 retry pending");
        expect_at(b, 4, 2'b11, 1'b1, "R9 released on mode exit");
        expect_at(b, R + 2, 2'b11, 1'b1, "R9 stays released");
        ch_fault = 2'b01;
        step(1);
        ch_fault = 2'b00;
        step(2);
        strap = 2'b11;
        step(R + 4);
        strap = 2'b00;
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule